// File: doc/BRIEF.md
# Status Register Write Protection Guard

This block holds the 8-bit status register of a serial non-volatile memory and decides, on every cycle, whether a write to the array or to the status register itself may go ahead. The command decoder in front of it supplies single-cycle strobes: write enable, write disable, a status write with its data byte, and the end of a completed write command (chip select rising). The block also takes the level of the external write-protect pin (active low) and the address that is about to be written.

Three status bits are writable by software. A two-bit protection selector picks a protected region at the top of the array: the upper quarter, the upper half, or all of it. A lock bit, combined with the write-protect pin, can freeze the status register in hardware. A write-enable latch must be set before any write is allowed. The latch clears when the host disables it, and also at the end of each completed write. The status byte can be read combinationally at any time, and reading it has no side effect.

Top module: `sr_guard`

## Requirements
- R1: The status byte has the lock bit at bit 7, bits 6..4 at 0, the protection selector high bit at bit 3 and low bit at bit 2, the write-enable latch at bit 1, and bit 0 at 0.
- R2: A write-enable strobe sets the latch at the next clock edge and a write-disable strobe clears it. When both arrive in the same cycle, disable wins.
- R3: An allowed status write loads data bits 7, 3 and 2 into the lock bit and the selector, and the other data bits have no effect on the status byte. The latch is left unchanged by the status write.
- R4: Selector 00 protects nothing. 01 protects 18000h..1FFFFh. 10 protects 10000h..1FFFFh. 11 protects 00000h..1FFFFh. The array is 17 address bits wide by default.
- R5: When the lock bit is 1 and the protect pin is low, `st_wr_ok` is 0 and a status write changes nothing.
- R6: When the lock bit is 0 or the protect pin is high, `st_wr_ok` equals the latch. A status write with `st_wr_ok` at 0 changes nothing.
- R7: `arr_wr_ok` is 1 exactly when the latch is set and `wr_addr` lies outside the protected region.
- R8: An end-of-write strobe clears the latch at the next edge, even when a write-enable strobe arrives in the same cycle.
- R9: After reset the latch is 0, and the lock bit and selector take the values of the parameters `RST_LOCK` and `RST_PSEL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wen | input | 1 | Write-enable strobe |
| cmd_wdis | input | 1 | Write-disable strobe |
| cmd_wst | input | 1 | Status write strobe |
| wst_data | input | 8 | Data byte of the status write |
| cmd_end | input | 1 | End of a completed write or status write |
| hw_lock_n | input | 1 | External write-protect pin, active low |
| wr_addr | input | ADDR_W | Address about to be written |
| status_q | output | 8 | Status byte for readback |
| arr_wr_ok | output | 1 | Array write allowed at `wr_addr` |
| st_wr_ok | output | 1 | Status write allowed |

## Verification
The bench builds the block with the default 17-bit address width and with non-zero reset values (`RST_LOCK`=1, `RST_PSEL`=01). With these values the reset check covers the parameter-driven reset path, and the first region boundary at 18000h is in effect from the first cycle. With the 17-bit width, each region boundary can be probed on both sides. All four selector codes are covered, along with the pin/lock combinations and the cases where two strobes arrive in the same cycle.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

  localparam int unsigned ST_W = 8;

  // Lower bound of the protected region for a selector code; code 0 has none.
  function automatic logic [31:0] region_base(input logic [1:0] code, input int unsigned aw);
    logic [31:0] b;
    case (code)
      2'd1:    b = 32'd3 << (aw - 2);
      2'd2:    b = 32'd1 << (aw - 1);
      default: b = 32'd0;
    endcase
    return b;
  endfunction

  // Status byte assembly: lock, zeros, selector, latch, zero.
  function automatic logic [ST_W-1:0] pack_status(input logic lock, input logic [1:0] psel,
                                                  input logic latch);
    return {lock, 3'b000, psel, latch, 1'b0};
  endfunction

  // Hardware freeze of the status register.
  function automatic logic hw_frozen(input logic lock, input logic pin_n);
    return lock & ~pin_n;
  endfunction

endpackage

// File: rtl/sr_wel_ctl.sv
module sr_wel_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic latch_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     latch_q <= 1'b0;
    else if (clr_i) latch_q <= 1'b0;
    else if (set_i) latch_q <= 1'b1;
  end
endmodule

// File: rtl/sr_cfg_reg.sv
module sr_cfg_reg #(
  parameter logic       RST_LOCK = 1'b0,
  parameter logic [1:0] RST_PSEL = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       lock_q,
  output logic [1:0] psel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= RST_LOCK;
      psel_q <= RST_PSEL;
    end else if (load_i) begin
      lock_q <= data_i[7];
      psel_q <= data_i[3:2];
    end
  end
endmodule

// File: rtl/sr_region_dec.sv
module sr_region_dec
  import sr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic [1:0]        psel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);
  localparam int unsigned NCODE = 4;

  logic [NCODE-1:0] hit;

  for (genvar g = 0; g < NCODE; g++) begin : g_code
    if (g == 0) begin : g_none
      assign hit[g] = 1'b0;
    end else begin : g_cmp
      localparam logic [31:0] BASE = region_base(2'(g), ADDR_W);
      assign hit[g] = ({{(32-ADDR_W){1'b0}}, addr_i} >= BASE);
    end
  end

  assign prot_o = hit[psel_i];
endmodule

// File: rtl/sr_guard.sv
module sr_guard
  import sr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W   = 17,
  parameter logic        RST_LOCK = 1'b0,
  parameter logic [1:0]  RST_PSEL = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wen,
  input  logic              cmd_wdis,
  input  logic              cmd_wst,
  input  logic [7:0]        wst_data,
  input  logic              cmd_end,
  input  logic              hw_lock_n,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        status_q,
  output logic              arr_wr_ok,
  output logic              st_wr_ok
);
  logic       latch;
  logic       lock;
  logic [1:0] psel;
  logic       in_region;

  // Named internal events.
  logic       latch_set_ev;
  logic       latch_clr_ev;
  logic       st_commit_ev;
  logic       frozen;

  assign frozen       = hw_frozen(lock, hw_lock_n);
  assign latch_set_ev = cmd_wen;
  assign latch_clr_ev = cmd_wdis | cmd_end;
  assign st_commit_ev = cmd_wst & st_wr_ok;

  sr_wel_ctl u_wel (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (latch_set_ev),
    .clr_i   (latch_clr_ev),
    .latch_q (latch)
  );

  sr_cfg_reg #(
    .RST_LOCK (RST_LOCK),
    .RST_PSEL (RST_PSEL)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (st_commit_ev),
    .data_i (wst_data),
    .lock_q (lock),
    .psel_q (psel)
  );

  sr_region_dec #(
    .ADDR_W (ADDR_W)
  ) u_dec (
    .psel_i (psel),
    .addr_i (wr_addr),
    .prot_o (in_region)
  );

  assign st_wr_ok  = latch & ~frozen;
  assign arr_wr_ok = latch & ~in_region;
  assign status_q  = pack_status(lock, psel, latch);
endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wen,
  input logic       cmd_wdis,
  input logic       cmd_wst,
  input logic       cmd_end,
  input logic       hw_lock_n,
  input logic [7:0] status_q,
  input logic       arr_wr_ok,
  input logic       st_wr_ok
);
  // R2
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wen && !cmd_wdis && !cmd_end) |=> status_q[1]);

  // R2
  latch_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wdis |=> !status_q[1]);

  // R8
  end_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_end |=> !status_q[1]);

  // R5
  hw_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[7] && !hw_lock_n) |-> !st_wr_ok);

  // R6
  denied_wst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wst && !st_wr_ok) |=> $stable(status_q[7:2]));

  // R7
  arr_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_ok |-> status_q[1]);

  // R4
  all_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[3:2] == 2'b11) |-> !arr_wr_ok);
endmodule

bind sr_guard sr_guard_chk u_chk (.*);

// File: tb/test_sr_guard.sv
module test_sr_guard;
  localparam int unsigned AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_wen = 0, cmd_wdis = 0, cmd_wst = 0, cmd_end = 0;
  logic [7:0]    wst_data = '0;
  logic          hw_lock_n = 1'b1;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    status_q;
  logic          arr_wr_ok, st_wr_ok;

  always #10 clk = ~clk;

  sr_guard #(.ADDR_W(AW), .RST_LOCK(1'b1), .RST_PSEL(2'b01)) i_sr_guard (
    .clk(clk), .rst_n(rst_n), .cmd_wen(cmd_wen), .cmd_wdis(cmd_wdis),
    .cmd_wst(cmd_wst), .wst_data(wst_data), .cmd_end(cmd_end),
    .hw_lock_n(hw_lock_n), .wr_addr(wr_addr), .status_q(status_q),
    .arr_wr_ok(arr_wr_ok), .st_wr_ok(st_wr_ok)
  );

  typedef struct {
    string    tag;
    logic [7:0] st;
    logic     arr;
    logic     sok;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0, n_fail = 0;
  bit   done = 0;

  // Independent model state
  logic       m_latch = 1'b0;
  logic       m_lock  = 1'b1;
  logic [1:0] m_psel  = 2'b01;

  function automatic logic protected_addr(input logic [1:0] p, input logic [AW-1:0] a);
    case (p)
      2'b00:   return 1'b0;
      2'b01:   return a[16] & a[15];
      2'b10:   return a[16];
      default: return 1'b1;
    endcase
  endfunction

  task automatic step(input logic wen, input logic wdis, input logic wst, input logic [7:0] d,
                      input logic endc, input logic pinn, input logic [AW-1:0] a, input string tag);
    logic ok_now;
    exp_t e;
    @(negedge clk);
    cmd_wen = wen; cmd_wdis = wdis; cmd_wst = wst; wst_data = d;
    cmd_end = endc; hw_lock_n = pinn; wr_addr = a;
    ok_now = m_latch && !(m_lock && !pinn);
    if (wst && ok_now) begin
      m_lock = d[7];
      m_psel = {d[3], d[2]};
    end
    if (wdis || endc) m_latch = 1'b0;
    else if (wen)     m_latch = 1'b1;
    e.tag = tag;
    e.st  = {m_lock, 3'b000, m_psel, m_latch, 1'b0};
    e.arr = m_latch && !protected_addr(m_psel, a);
    e.sok = m_latch && !(m_lock && !pinn);
    exp_q.push_back(e);
    @(posedge clk);
  endtask

  // Monitor: samples a quarter period after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_run++;
        if (status_q !== e.st || arr_wr_ok !== e.arr || st_wr_ok !== e.sok) begin
          n_fail++;
          $display("FAIL %s: status=%h arr=%b st=%b expected status=%h arr=%b st=%b",
                   e.tag, status_q, arr_wr_ok, st_wr_ok, e.st, e.arr, e.sok);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0,0,0,8'h00,0,1,17'h00000, "R9 reset state");
    step(1,0,0,8'h00,0,1,17'h00000, "R2 enable sets latch");
    step(0,0,0,8'h00,0,1,17'h17FFF, "R4 sel01 below boundary");
    step(0,0,0,8'h00,0,1,17'h18000, "R4 sel01 at boundary");
    step(0,0,1,8'hFF,0,1,17'h00000, "R3 R1 status write all ones");
    step(0,0,0,8'h00,0,1,17'h00000, "R4 sel11 protects all");
    step(0,0,0,8'h00,1,1,17'h00000, "R8 end clears latch");
    step(1,0,0,8'h00,0,0,17'h00000, "R5 frozen with latch set");
    step(0,0,1,8'h00,0,0,17'h00000, "R5 frozen write ignored");
    step(0,0,0,8'h00,0,1,17'h00000, "R6 pin high allows");
    step(0,0,1,8'h08,0,1,17'h00000, "R3 write selects half");
    step(0,0,0,8'h00,0,1,17'h0FFFF, "R7 sel10 below boundary");
    step(0,0,0,8'h00,0,1,17'h10000, "R4 sel10 at boundary");
    step(1,1,0,8'h00,0,1,17'h00000, "R2 disable wins over enable");
    step(0,0,1,8'h84,0,1,17'h00000, "R6 write without latch ignored");
    step(1,0,0,8'h00,0,0,17'h00000, "R6 lock clear pin low allows");
    step(0,0,1,8'h00,0,0,17'h1FFFF, "R4 sel00 protects none");
    step(1,0,0,8'h00,1,1,17'h00000, "R8 end wins over enable");
    step(1,0,0,8'h00,0,1,17'h1FFFF, "R7 latch set top address");
    step(0,1,0,8'h00,0,1,17'h1FFFF, "R2 disable clears latch");
    step(0,0,0,8'h00,0,1,17'h00000, "R1 idle readback");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule